// File: doc/BRIEF.md
# Trigger-Launched Parallel Byte Burst Engine

This block holds one frame of bytes that a host processor writes ahead of time. Once the whole frame is loaded, the host arms the block. A rising edge on an external trigger pin then sends the frame to an external device over an 8-bit parallel bus. Each byte goes out with one write strobe. The processor takes no part in the burst, so its interrupt latency and jitter are not part of the transfer time.

The trigger passes through a synchronizer before its edge is detected. Each byte occupies a fixed slot of `SLOT_CYC` clocks. The strobe is high for the first `STROBE_CYC` clocks of the slot, and the data is held for the whole slot. The receiver never inserts wait states. With the defaults (15 bytes, 4-clock slots, a 60 MHz clock), the burst takes 60 clocks, which is about 1 µs. When the last slot ends, a sticky completion flag is raised. The flag stays high until the host arms the block for the next frame.

Top module: `trig_burst_sender`

## Requirements
- R1: After reset, `bus_wr`, `bus_data` and `done_irq` are 0, and a trigger edge starts no burst until a full frame has been written and the block armed.
- R2: The first strobe goes high on the third rising clock edge after `trig_in` is first sampled high. Two of these edges are synchronizer stages and one is the state update.
- R3: A burst presents the bytes stored at addresses 0 to `FRAME_LEN-1` in ascending order. Consecutive strobe rises are exactly `SLOT_CYC` clocks apart.
- R4: Each strobe is high for exactly `STROBE_CYC` clocks. `bus_data` does not change while the strobe is high.
- R5: A burst produces exactly `FRAME_LEN` strobes. `done_irq` rises on the clock edge that ends the last slot, which is `FRAME_LEN*SLOT_CYC` clocks after the first strobe rises.
- R6: `done_irq` stays high until the host raises `host_arm` and the arm is accepted. An accepted arm clears it.
- R7: An arm is accepted only when every address 0 to `FRAME_LEN-1` has been written since the last burst started. Otherwise `host_arm` has no effect.
- R8: Only a rising edge of the synchronized trigger, seen while the block is armed, starts a burst. Edges seen while idle or done start nothing. A trigger held high while the block is armed starts nothing.
- R9: Host writes made during a burst change neither the bytes of that burst nor the written-address record.
- R10: A write to an address of `FRAME_LEN` or above stores nothing and does not count toward a full frame.
- R11: `bus_data` is 0 whenever no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_we | input | 1 | Byte write enable from the host |
| host_addr | input | ADDR_W | Frame byte address |
| host_wdata | input | DATA_W | Frame byte value |
| host_arm | input | 1 | Arm request, one clock wide |
| trig_in | input | 1 | Asynchronous trigger that launches the burst |
| bus_data | output | DATA_W | Parallel data toward the external device |
| bus_wr | output | 1 | Write strobe for the external device |
| done_irq | output | 1 | Sticky completion flag to the host |

## Verification
The bench measures the trigger-to-strobe latency and the slot spacing at the pins. A design that drops or adds a synchronizer stage, or miscounts the slot, misses the cycle at which the bench expects each event. It loads a frame short by one address, or with one byte sent to an address past the frame, and then arms. A design that accepts such an arm would raise a burst, and it would also clear `done_irq`. A trigger is held high while the block is armed to catch level-sensitive starting. The host rewrites the frame in the middle of a burst, so a store that is not locked during the burst would send corrupted later bytes.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2,
    ST_DONE  = 2'd3
  } burst_state_t;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/burst_trig_sync.sv
module burst_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic trig_rise
);
  logic [SYNC_STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-1:0], trig_async};
  end

  // the last stage only holds the previous synchronized value, for edge detection
  assign trig_rise = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
endmodule

// File: rtl/burst_frame_store.sv
module burst_frame_store #(
  parameter int FRAME_LEN = 15,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_mask,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              full
);
  logic [DATA_W-1:0]    mem_q [FRAME_LEN];
  logic [FRAME_LEN-1:0] wr_hit;
  logic [FRAME_LEN-1:0] seen_q;

  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_entry
    assign wr_hit[g] = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem_q[g] <= '0;
      else if (wr_hit[g]) mem_q[g] <= wr_data;
    end

    // the clear taken at burst start wins over a write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_q[g] <= 1'b0;
      else if (clr_mask)  seen_q[g] <= 1'b0;
      else if (wr_hit[g]) seen_q[g] <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < FRAME_LEN; i++) begin
      if (rd_idx == ADDR_W'(i)) rd_data = mem_q[i];
    end
  end

  assign full = &seen_q;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int FRAME_LEN  = 15,
  parameter int SLOT_CYC   = 4,
  parameter int STROBE_CYC = 2,
  parameter int ADDR_W     = 4,
  localparam int SLOT_W    = $clog2(SLOT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_req,
  input  logic              frame_full,
  input  logic              trig_rise,
  output burst_state_t      st,
  output logic [ADDR_W-1:0] byte_idx,
  output logic              mask_clr,
  output logic              strobe,
  output logic              done_flag
);
  localparam logic [ADDR_W-1:0] LAST_IDX  = ADDR_W'(FRAME_LEN - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_CYC - 1);
  localparam logic [SLOT_W-1:0] STB_END   = SLOT_W'(STROBE_CYC);

  burst_state_t      st_q, st_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              done_q, done_d;
  logic              start_d;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    slot_d  = slot_q;
    done_d  = done_q;
    start_d = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (arm_req && frame_full) begin
          st_d   = ST_ARMED;
          idx_d  = '0;
          slot_d = '0;
          done_d = 1'b0;
        end
      end
      ST_ARMED: begin
        if (trig_rise) begin
          st_d    = ST_SEND;
          idx_d   = '0;
          slot_d  = '0;
          start_d = 1'b1;
        end
      end
      ST_SEND: begin
        if (slot_q == LAST_SLOT) begin
          slot_d = '0;
          if (idx_q == LAST_IDX) begin
            st_d   = ST_DONE;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      slot_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      slot_q <= slot_d;
      done_q <= done_d;
    end
  end

  assign st        = st_q;
  assign byte_idx  = idx_q;
  assign mask_clr  = start_d;
  assign strobe    = (st_q == ST_SEND) && (slot_q < STB_END);
  assign done_flag = done_q;
endmodule

// File: rtl/trig_burst_sender.sv
module trig_burst_sender
  import burst_pkg::*;
#(
  parameter int FRAME_LEN   = 15,
  parameter int DATA_W      = 8,
  parameter int SLOT_CYC    = 4,
  parameter int STROBE_CYC  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_arm,
  input  logic              trig_in,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_wr,
  output logic              done_irq
);
  logic              rst_i_n;
  logic              trig_rise;
  logic              frame_full;
  logic              mask_clr;
  logic              store_we;
  logic [ADDR_W-1:0] byte_idx;
  logic [DATA_W-1:0] rd_byte;
  burst_state_t      st;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  burst_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .trig_async (trig_in),
    .trig_rise  (trig_rise)
  );

  // the store is locked while a burst runs
  assign store_we = host_we && (st != ST_SEND);

  burst_frame_store #(
    .FRAME_LEN (FRAME_LEN),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (store_we),
    .wr_addr  (host_addr),
    .wr_data  (host_wdata),
    .clr_mask (mask_clr),
    .rd_idx   (byte_idx),
    .rd_data  (rd_byte),
    .full     (frame_full)
  );

  burst_seq #(
    .FRAME_LEN  (FRAME_LEN),
    .SLOT_CYC   (SLOT_CYC),
    .STROBE_CYC (STROBE_CYC),
    .ADDR_W     (ADDR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .arm_req    (host_arm),
    .frame_full (frame_full),
    .trig_rise  (trig_rise),
    .st         (st),
    .byte_idx   (byte_idx),
    .mask_clr   (mask_clr),
    .strobe     (bus_wr),
    .done_flag  (done_irq)
  );

  assign bus_data = (st == ST_SEND) ? rd_byte : '0;
endmodule

// File: rtl/trig_burst_sender_chk.sv
module trig_burst_sender_chk
  import burst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input burst_state_t      st,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_data,
  input logic              done_irq,
  input logic              host_arm
);
  p_wr_in_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> st == ST_SEND);

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && $past(bus_wr)) |-> $stable(bus_data));

  p_done_from_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(st) == ST_SEND);

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !host_arm) |=> done_irq);

  p_start_from_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEND && $past(st) != ST_SEND) |-> $past(st) == ST_ARMED);

  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st != ST_SEND |-> bus_data == '0);
endmodule

bind trig_burst_sender trig_burst_sender_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .st       (st),
  .bus_wr   (bus_wr),
  .bus_data (bus_data),
  .done_irq (done_irq),
  .host_arm (host_arm)
);

// File: tb/trig_burst_sender_tb_top.sv
`timescale 1ns/1ps
module trig_burst_sender_tb_top;
  localparam int FRAME_LEN  = 15;
  localparam int DATA_W     = 8;
  localparam int SLOT_CYC   = 4;
  localparam int STROBE_CYC = 2;
  localparam int ADDR_W     = $clog2(FRAME_LEN);
  localparam int LAT_FIRST  = 3;
  localparam int LAT_DONE   = LAT_FIRST + FRAME_LEN * SLOT_CYC;
  localparam int NVEC       = 4;
  // each vector: {first byte, increment}; byte i = first + i*increment
  localparam logic [15:0] VEC [NVEC] = '{16'h0001, 16'hA511, 16'hFFFF, 16'h3C80};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              host_we;
  logic [ADDR_W-1:0] host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic              host_arm;
  logic              trig_in;
  logic [DATA_W-1:0] bus_data;
  logic              bus_wr;
  logic              done_irq;

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] cap [64];
  int cap_n = 0;
  int run_len = 0;
  int since_rise = 0;
  logic prev_wr = 1'b0;
  int first_at, done_at;

  always #2.5 clk = ~clk;

  trig_burst_sender dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_arm(host_arm), .trig_in(trig_in),
    .bus_data(bus_data), .bus_wr(bus_wr), .done_irq(done_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe monitor, sampling on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_wr && !prev_wr) begin
        if (cap_n > 0 && cap_n < FRAME_LEN)
          check(since_rise == SLOT_CYC, "R3 slot spacing", since_rise, SLOT_CYC);
        if (cap_n < 64) cap[cap_n] = bus_data;
        cap_n++;
        run_len = 1;
        since_rise = 1;
      end else begin
        since_rise++;
        if (bus_wr) begin
          run_len++;
          check(bus_data == cap[cap_n-1], "R4 data stable", bus_data, cap[cap_n-1]);
        end
      end
      if (!bus_wr && prev_wr)
        check(run_len == STROBE_CYC, "R4 strobe width", run_len, STROBE_CYC);
      if (!bus_wr && !prev_wr && cap_n == 0)
        check(bus_data == 0, "R11 idle bus", bus_data, 0);
      prev_wr = bus_wr;
    end
  end

  task automatic wr_byte(input int a, input int d);
    @(negedge clk);
    host_we = 1'b1; host_addr = ADDR_W'(a); host_wdata = DATA_W'(d);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic load_frame(input logic [7:0] base, input logic [7:0] step);
    for (int i = 0; i < FRAME_LEN; i++) wr_byte(i, base + 8'(i) * step);
  endtask

  task automatic do_arm();
    @(negedge clk); host_arm = 1'b1;
    @(negedge clk); host_arm = 1'b0;
  endtask

  // raise the trigger and watch for up to 'span' cycles
  task automatic fire(input int span);
    cap_n = 0; first_at = -1; done_at = -1;
    @(negedge clk); trig_in = 1'b1;
    for (int n = 1; n <= span; n++) begin
      @(negedge clk);
      if (bus_wr && first_at < 0) first_at = n;
      if (done_irq && done_at < 0) done_at = n;
    end
    trig_in = 1'b0;
  endtask

  task automatic expect_frame(input logic [7:0] base, input logic [7:0] step);
    check(cap_n == FRAME_LEN, "R5 strobe count", cap_n, FRAME_LEN);
    for (int i = 0; i < FRAME_LEN; i++) begin
      logic [7:0] e;
      e = base + 8'(i) * step;
      check(cap[i] == e, "R3 byte order", cap[i], e);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    host_arm = 1'b0; trig_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, and a trigger with nothing armed
    check(bus_wr == 0 && done_irq == 0 && bus_data == 0, "R1 reset outputs",
          {bus_wr, done_irq}, 0);
    fire(20);
    check(cap_n == 0, "R1 no burst before arm", cap_n, 0);

    // table of frames
    for (int v = 0; v < NVEC; v++) begin
      load_frame(VEC[v][15:8], VEC[v][7:0]);
      do_arm();
      check(done_irq == 0, "R6 arm clears done", done_irq, 0);
      fire(LAT_DONE + 5);
      check(first_at == LAT_FIRST, "R2 trigger latency", first_at, LAT_FIRST);
      check(done_at == LAT_DONE, "R5 done timing", done_at, LAT_DONE);
      expect_frame(VEC[v][15:8], VEC[v][7:0]);
      repeat (10) @(negedge clk);
      check(done_irq == 1, "R6 done sticky", done_irq, 1);
    end

    // R8: trigger while done starts nothing
    fire(30);
    check(cap_n == 0, "R8 edge while done ignored", cap_n, 0);

    // R7: one address missing, arm rejected (done stays set)
    for (int i = 0; i < FRAME_LEN - 1; i++) wr_byte(i, 8'h50 + i);
    do_arm();
    check(done_irq == 1, "R7 partial frame arm rejected", done_irq, 1);
    fire(30);
    check(cap_n == 0, "R7 no burst after rejected arm", cap_n, 0);

    // R10: write past the frame does not complete it
    wr_byte(FRAME_LEN, 8'h77);
    do_arm();
    check(done_irq == 1, "R10 out-of-range write not counted", done_irq, 1);

    // R8: trigger already high when armed does not start
    wr_byte(FRAME_LEN - 1, 8'h5E);
    @(negedge clk); trig_in = 1'b1;
    repeat (5) @(negedge clk);
    do_arm();
    check(done_irq == 0, "R7 full frame arm accepted", done_irq, 0);
    cap_n = 0;
    repeat (20) @(negedge clk);
    check(cap_n == 0, "R8 held level ignored", cap_n, 0);
    @(negedge clk); trig_in = 1'b0;
    repeat (3) @(negedge clk);

    // R9: rewrite every address during the burst
    fork
      fire(LAT_DONE + 5);
      begin
        repeat (LAT_FIRST + 2) @(negedge clk);
        for (int i = 0; i < FRAME_LEN; i++) wr_byte(i, 8'hEE);
      end
    join
    expect_frame(8'h50, 8'h01);
    check(done_at == LAT_DONE, "R5 done timing", done_at, LAT_DONE);
    do_arm();
    check(done_irq == 1, "R9 writes during burst not recorded", done_irq, 1);

    // R1: reset mid-burst clears everything
    load_frame(8'h10, 8'h02);
    do_arm();
    @(negedge clk); trig_in = 1'b1;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(bus_wr == 0 && bus_data == 0 && done_irq == 0, "R1 reset in burst",
          {bus_wr, done_irq}, 0);
    trig_in = 1'b0; rst_n = 1'b1;
    prev_wr = 1'b0; cap_n = 0;
    repeat (4) @(negedge clk);
    fire(30);
    check(cap_n == 0, "R1 unarmed after reset", cap_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule